// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Loader

This block keeps the two thresholds that a FIFO compares its fill levels against, and from them produces the active-low almost-empty and almost-full flags. The almost-empty threshold (the "low-water" offset) is compared with the number of stored words on the read clock. The almost-full threshold (the "high-water" offset) is compared with the number of free locations on the write clock. Both fill levels arrive already synchronized to the clock of the flag that uses them. The FIFO array and its pointers live elsewhere.

The way the thresholds get their values is chosen while master reset is held low. There are three options. A fixed preset can be applied to both thresholds. The thresholds can be written as the first two words on the write-side data bus. Or they can be streamed in one bit per write clock, through two pins that act as flag-select inputs during master reset. A partial reset flushes the FIFO's fill state and forces the flags to their empty-FIFO values. It keeps the chosen method, the thresholds and any loading progress.

Top module: `almost_flag_offsets`

## Requirements
- R1: At every write/read clock edge where `mrst_n` is low, `ae_n` is driven to 0 and `af_n` to 1.
- R2: With `serial_n` low during master reset, serial loading is selected. After reset, each write clock edge with `fs1_sen_n` low shifts `fs0_sdat` into a 2×OFS_W-bit chain. The first bit becomes the high-water MSB and bit number 2×OFS_W becomes the low-water LSB. Both thresholds are 0 until loaded.
- R3: Write clock edges with `fs1_sen_n` high do not shift. Bits presented after 2×OFS_W have been taken are ignored.
- R4: With `serial_n` high during master reset, `{fs1_sen_n,fs0_sdat}` = 01, 10 or 11 sets both thresholds to 8, 16 or 64 respectively.
- R5: With `serial_n` high and `{fs1_sen_n,fs0_sdat}` = 00 during master reset, parallel loading is selected. After reset, the first `wr_en` cycle loads the low-water threshold from `wr_data_lo` and the second loads the high-water threshold. Later writes leave both unchanged. Both are 0 until loaded.
- R6: `ae_n` is registered on `clk_rd`. One edge after `rd_level` is presented, it is 0 when `rd_level` ≤ low-water threshold and 1 otherwise.
- R7: `af_n` is registered on `clk_wr`. One edge after `wr_space` is presented, it is 0 when `wr_space` ≤ high-water threshold and 1 otherwise.
- R8: At edges where `prst_n` is low, `ae_n` goes to 0 and `af_n` to 1. The thresholds, the loading method and the loading progress are all kept.
- R9: While `mrst_n` is high, `serial_n` and the select pins do not change the method. In preset mode, neither `fs1_sen_n` low nor `wr_en` alters the thresholds.
- R10: A `wr_en` on an edge where `mrst_n` is low is dropped. A serial bit on an edge where `prst_n` is low is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | Write-side clock; loading and almost-full flag |
| clk_rd | input | 1 | Read-side clock; almost-empty flag |
| mrst_n | input | 1 | Master reset, active low, synchronous, held ≥4 edges of each clock |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| serial_n | input | 1 | Method select sampled in master reset: 0 = serial |
| fs1_sen_n | input | 1 | Select bit 1 in master reset; serial shift enable (active low) after |
| fs0_sdat | input | 1 | Select bit 0 in master reset; serial data bit after |
| wr_en | input | 1 | Write strobe of the write-side data port |
| wr_data_lo | input | OFS_W | Low bits of the write-side data bus |
| rd_level | input | OFS_W+1 | Stored word count, read-clock domain |
| wr_space | input | OFS_W+1 | Free location count, write-clock domain |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
Two pairs of events are made to meet on one edge. In the first, a serial bit shift and a partial reset land on the same write clock edge, midway through a 20-bit stream. The flags must show their reset values at that edge, and the later threshold probes must show that the bit was still taken. In the second, a parallel write coincides with the final master-reset edge. Probing the thresholds at zero afterwards shows the write was dropped, and the two following writes become the low-water and high-water values.

// File: rtl/ofl_pkg.sv
`timescale 1ns/1ps
package ofl_pkg;

  typedef enum logic [1:0] {
    LD_PRESET   = 2'd0,
    LD_PARALLEL = 2'd1,
    LD_SERIAL   = 2'd2
  } load_mode_e;

  // Loading method from the pins sampled during master reset.
  function automatic load_mode_e pick_mode(input logic serial_n, input logic [1:0] fs);
    if (!serial_n)        return LD_SERIAL;
    else if (fs == 2'b00) return LD_PARALLEL;
    else                  return LD_PRESET;
  endfunction

  // Preset threshold for select codes 01/10/11.
  function automatic logic [15:0] preset_ofs(input logic [1:0] fs);
    case (fs)
      2'b01:   return 16'd8;
      2'b10:   return 16'd16;
      default: return 16'd64;
    endcase
  endfunction

  // Flag hit: level at or below the threshold.
  function automatic logic at_or_below(input logic [31:0] level, input logic [31:0] limit);
    return level <= limit;
  endfunction

endpackage

// File: rtl/ofl_cfg_latch.sv
`timescale 1ns/1ps
module ofl_cfg_latch
  import ofl_pkg::*;
(
  input  logic       clk,
  input  logic       mrst_n,
  input  logic       serial_n,
  input  logic [1:0] fs,
  output load_mode_e mode_o
);

  logic capture;
  assign capture = ~mrst_n;

  always_ff @(posedge clk) begin
    if (capture) mode_o <= pick_mode(serial_n, fs);
  end

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n |=> $stable(mode_o));

endmodule

// File: rtl/ofl_loader.sv
`timescale 1ns/1ps
module ofl_loader
  import ofl_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  load_mode_e       mode_i,
  input  logic             serial_n,
  input  logic [1:0]       fs,
  input  logic             wr,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] low_o,
  output logic [OFS_W-1:0] high_o
);

  localparam int SER_LEN = 2 * OFS_W;
  localparam int SCW     = $clog2(SER_LEN + 1);

  logic [SER_LEN-1:0] chain_q;
  logic [SCW-1:0]     nbits_q;
  logic [1:0]         nwr_q;

  logic       sen_n, sdat, ser_room;
  logic       shift_evt, pload_evt;
  load_mode_e rst_mode;

  assign sen_n    = fs[1];
  assign sdat     = fs[0];
  assign ser_room = nbits_q < SCW'(SER_LEN);
  assign rst_mode = pick_mode(serial_n, fs);

  assign shift_evt = mrst_n && (mode_i == LD_SERIAL)   && !sen_n && ser_room;
  assign pload_evt = mrst_n && (mode_i == LD_PARALLEL) && wr && (nwr_q != 2'd2);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      nbits_q <= '0;
      nwr_q   <= '0;
      if (rst_mode == LD_PRESET)
        chain_q <= {2{OFS_W'(preset_ofs(fs))}};
      else
        chain_q <= '0;
    end else if (shift_evt) begin
      chain_q <= {chain_q[SER_LEN-2:0], sdat};
      nbits_q <= nbits_q + SCW'(1);
    end else if (pload_evt) begin
      if (nwr_q == 2'd0) chain_q[OFS_W-1:0]       <= din;
      else               chain_q[SER_LEN-1:OFS_W] <= din;
      nwr_q <= nwr_q + 2'd1;
    end
  end

  assign low_o  = chain_q[OFS_W-1:0];
  assign high_o = chain_q[SER_LEN-1:OFS_W];

  // R8 R9
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!shift_evt && !pload_evt) |=> $stable(chain_q));

  // R2 R3
  shift_bit_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    shift_evt |=> (nbits_q != '0) && (chain_q[0] == $past(sdat)));

  // R5
  pload_cnt_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    pload_evt |=> (nwr_q != 2'd0));

endmodule

// File: rtl/ofl_flag_gen.sv
`timescale 1ns/1ps
module ofl_flag_gen
  import ofl_pkg::*;
#(
  parameter int   OFS_W   = 10,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic [OFS_W:0]   level_i,
  input  logic [OFS_W-1:0] limit_i,
  output logic             flag_n_o
);

  logic hit;
  assign hit = at_or_below(32'(level_i), 32'(limit_i));

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) flag_n_o <= RST_VAL;
    else                    flag_n_o <= ~hit;
  end

  // R6 R7
  level_low_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    ({1'b0, limit_i} >= level_i) |=> !flag_n_o);

  // R6 R7
  level_high_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    ({1'b0, limit_i} < level_i) |=> flag_n_o);

  // R8
  part_rst_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (flag_n_o == RST_VAL));

endmodule

// File: rtl/almost_flag_offsets.sv
`timescale 1ns/1ps
module almost_flag_offsets
  import ofl_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk_wr,
  input  logic             clk_rd,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             serial_n,
  input  logic             fs1_sen_n,
  input  logic             fs0_sdat,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_data_lo,
  input  logic [OFS_W:0]   rd_level,
  input  logic [OFS_W:0]   wr_space,
  output logic             ae_n,
  output logic             af_n
);

  logic [1:0]       fs_pins;
  load_mode_e       mode;
  logic [OFS_W-1:0] low_ofs, high_ofs;

  assign fs_pins = {fs1_sen_n, fs0_sdat};

  ofl_cfg_latch u_cfg (
    .clk      (clk_wr),
    .mrst_n   (mrst_n),
    .serial_n (serial_n),
    .fs       (fs_pins),
    .mode_o   (mode)
  );

  ofl_loader #(.OFS_W(OFS_W)) u_load (
    .clk      (clk_wr),
    .mrst_n   (mrst_n),
    .mode_i   (mode),
    .serial_n (serial_n),
    .fs       (fs_pins),
    .wr       (wr_en),
    .din      (wr_data_lo),
    .low_o    (low_ofs),
    .high_o   (high_ofs)
  );

  ofl_flag_gen #(.OFS_W(OFS_W), .RST_VAL(1'b0)) u_ae (
    .clk      (clk_rd),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .level_i  (rd_level),
    .limit_i  (low_ofs),
    .flag_n_o (ae_n)
  );

  ofl_flag_gen #(.OFS_W(OFS_W), .RST_VAL(1'b1)) u_af (
    .clk      (clk_wr),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .level_i  (wr_space),
    .limit_i  (high_ofs),
    .flag_n_o (af_n)
  );

endmodule

// File: tb/almost_flag_offsets_test.sv
`timescale 1ns/1ps
module almost_flag_offsets_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        mrst_n = 1'b0, prst_n = 1'b1, serial_n = 1'b1;
  logic        fs1_sen_n = 1'b0, fs0_sdat = 1'b1, wr_en = 1'b0;
  logic [9:0]  wr_data_lo = '0;
  logic [10:0] rd_level = 11'd500, wr_space = 11'd0;
  logic        ae_n, af_n;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  almost_flag_offsets #(.OFS_W(10)) uut (
    .clk_wr(clk), .clk_rd(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .serial_n(serial_n), .fs1_sen_n(fs1_sen_n), .fs0_sdat(fs0_sdat),
    .wr_en(wr_en), .wr_data_lo(wr_data_lo), .rd_level(rd_level),
    .wr_space(wr_space), .ae_n(ae_n), .af_n(af_n)
  );

  typedef struct packed {
    logic [1:0]  fs;
    logic [10:0] lvl;
    logic        ae;
    logic        af;
  } vec_t;

  // R4 R6 R7: preset codes and threshold probes
  localparam vec_t VEC [10] = '{
    '{2'd1, 11'd8,    1'b0, 1'b0},
    '{2'd1, 11'd9,    1'b1, 1'b1},
    '{2'd1, 11'd0,    1'b0, 1'b0},
    '{2'd1, 11'd7,    1'b0, 1'b0},
    '{2'd2, 11'd16,   1'b0, 1'b0},
    '{2'd2, 11'd17,   1'b1, 1'b1},
    '{2'd2, 11'd9,    1'b0, 1'b0},
    '{2'd3, 11'd64,   1'b0, 1'b0},
    '{2'd3, 11'd65,   1'b1, 1'b1},
    '{2'd3, 11'd1024, 1'b1, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_mrst(input logic ser_n, input logic [1:0] fs);
    mrst_n = 1'b0; serial_n = ser_n; {fs1_sen_n, fs0_sdat} = fs;
    repeat (4) tick();
    mrst_n = 1'b1;
  endtask

  task automatic probe_low(input int exp, input string req);
    rd_level = 11'(exp); tick(); chk(req, ae_n, 1'b0);
    rd_level = 11'(exp + 1); tick(); chk(req, ae_n, 1'b1);
  endtask

  task automatic probe_high(input int exp, input string req);
    wr_space = 11'(exp); tick(); chk(req, af_n, 1'b0);
    wr_space = 11'(exp + 1); tick(); chk(req, af_n, 1'b1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [19:0] stream;
    @(negedge clk);
    // R1: reset values on the first edge, with levels that would say otherwise
    tick();
    chk("R1 ae_n", ae_n, 1'b0);
    chk("R1 af_n", af_n, 1'b1);

    // Table of preset vectors
    for (int i = 0; i < 10; i++) begin
      do_mrst(1'b1, VEC[i].fs);
      rd_level = VEC[i].lvl; wr_space = VEC[i].lvl;
      tick();
      chk("R4 R6 ae_n", ae_n, VEC[i].ae);
      chk("R4 R7 af_n", af_n, VEC[i].af);
    end

    // R2 R3 R10: serial stream high=300 low=5
    do_mrst(1'b0, 2'b11);
    rd_level = 11'd1000; wr_space = 11'd1000;
    stream = {10'd300, 10'd5};
    for (int i = 0; i < 20; i++) begin
      if (i == 4) begin
        fs1_sen_n = 1'b1; fs0_sdat = 1'b1; tick();   // R3 no shift
      end
      fs1_sen_n = 1'b0; fs0_sdat = stream[19 - i];
      if (i == 10) prst_n = 1'b0;                   // R10 coincide
      tick();
      if (i == 10) begin
        chk("R8 ae_n forced", ae_n, 1'b0);
        chk("R8 af_n forced", af_n, 1'b1);
        prst_n = 1'b1;
      end
    end
    fs0_sdat = 1'b1;
    repeat (3) tick();                              // R3 extra bits
    fs1_sen_n = 1'b1;
    probe_low(5, "R2 R3 R10 low");
    probe_high(300, "R2 R3 R10 high");

    // R8: partial reset keeps the thresholds
    prst_n = 1'b0; tick(); prst_n = 1'b1;
    probe_low(5, "R8 low");
    probe_high(300, "R8 high");

    // R9: method pins ignored outside master reset
    serial_n = 1'b1; fs1_sen_n = 1'b0; fs0_sdat = 1'b1;
    repeat (3) tick();
    fs1_sen_n = 1'b1;
    probe_low(5, "R9 low");

    // R9: preset mode ignores shift enable and writes
    do_mrst(1'b1, 2'b01);
    fs1_sen_n = 1'b0; fs0_sdat = 1'b1; wr_en = 1'b1; wr_data_lo = 10'd3;
    repeat (5) tick();
    wr_en = 1'b0; fs1_sen_n = 1'b1;
    probe_low(8, "R9 preset low");
    probe_high(8, "R9 preset high");

    // R5 R10: parallel load; write on the last reset edge is dropped
    mrst_n = 1'b0; serial_n = 1'b1; fs1_sen_n = 1'b0; fs0_sdat = 1'b0;
    repeat (3) tick();
    wr_en = 1'b1; wr_data_lo = 10'd77;
    tick();
    mrst_n = 1'b1; wr_en = 1'b0;
    probe_low(0, "R10 low");
    probe_high(0, "R10 high");
    wr_en = 1'b1; wr_data_lo = 10'd12;  tick();
    wr_en = 1'b0; tick();
    wr_en = 1'b1; wr_data_lo = 10'd700; tick();
    wr_en = 1'b1; wr_data_lo = 10'd3;   tick();
    wr_en = 1'b0;
    probe_low(12, "R5 low");
    probe_high(700, "R5 high");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule